// File: doc/BRIEF.md
# Serial EEPROM Station-Address Loader

This block runs by itself once reset is released, and again on each start request while it is idle. It reads a 64-word image from a three-wire serial EEPROM. The EEPROM has a chip select, a shift clock, a serial data input and a serial data output. The block first works out whether the part uses 6-bit or 8-bit word addresses. It does this with a probe read of word 0 that uses the short address format. Every later read uses the address width that the probe selected.

The block then fetches all words in ascending order and adds them modulo 2^16. When the total equals a fixed signature, it presents a 48-bit station address built from the first three words and raises a valid flag. When the total does not match, the address output stays at zero. In both cases a one-cycle completion pulse marks the end of the load.

The serial bit rate comes from a system-clock divider parameter. Each level of the shift clock lasts that many system clocks.

Top module: `eeprom_addr_loader`

## Requirements
- R1: While reset is high, `ee_cs`, `ee_sck`, `ee_di`, `addr_valid`, `load_done` and `station_addr` are all 0. When reset is released, a full load begins with no start request.
- R2: Each access shifts out a 13-bit frame, MSB first. The frame is zero padding, then the opcode `3'b110`, then the word address. `ee_di` changes only while `ee_sck` is low, so it is stable at every rising edge of `ee_sck`.
- R3: Before each access, `ee_cs` stays low for at least one bit time (two half-periods). It is then raised for the frame, and dropped again after the 16th data bit. `ee_sck` is never high while `ee_cs` is low.
- R4: The first access reads word 0 with a 6-bit address. If it returns `16'hFFFF`, every later access uses an 8-bit address. Otherwise every later access uses a 6-bit address.
- R5: Each access returns 16 data bits, MSB first. Each bit is sampled from `ee_do` at the end of an `ee_sck` high level.
- R6: After the probe, words 0 to 63 are read exactly once each, in ascending order. The image is valid only when their sum modulo 2^16 equals `16'hBABA`.
- R7: With a valid image, `station_addr[15:0]` = word0, `[31:16]` = word1 and `[47:32]` = word2. So the first address byte `[7:0]` is the low byte of word0, and the bytes follow low byte first.
- R8: With a sum mismatch, `station_addr` is all zeros and `addr_valid` is 0 when the load completes.
- R9: `load_done` is a single-cycle pulse, raised once per load after the sum has been checked. A start request while idle clears `addr_valid` and `station_addr` and begins a new load. A start request during a load has no effect.
- R10: Each high level of `ee_sck` lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new load while idle |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sck | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| station_addr | output | 48 | Station address, first byte in bits [7:0] |
| addr_valid | output | 1 | Image sum matched the signature |
| load_done | output | 1 | One-cycle pulse at the end of each load |

## Verification
The assertions check the wire-level rules on every cycle: data-in is steady while the shift clock is high, the shift clock stays low while deselected, the divider stays within range, completion lasts one cycle, an invalid result carries a zero address, and the address holds outside the load boundaries. The bench scenarios are the only way to show the rest: the frame contents and ascending word order seen by an EEPROM model, the switch to 8-bit addressing for a part that answers the probe with all ones, the sum comparison, the byte packing, the deselect and high-level timing, and that a start request during a load is ignored.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam logic [2:0] RD_OPCODE  = 3'b110;
  localparam int         FRAME_BITS = 13;
  localparam int         DATA_BITS  = 16;

  typedef logic [DATA_BITS-1:0] word_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_DESEL, RS_CMD_LO, RS_CMD_HI, RS_DAT_LO, RS_DAT_HI, RS_FIN
  } rd_state_e;

  typedef enum logic [2:0] {
    SQ_KICK, SQ_PROBE, SQ_REQ, SQ_WAIT, SQ_CHECK, SQ_IDLE
  } sq_state_e;

  // Opcode and masked address, right-aligned in a fixed frame; zero padding leads.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] waddr,
                                                        input logic wide,
                                                        input int narrow_aw,
                                                        input int wide_aw);
    int aw;
    logic [FRAME_BITS-1:0] f;
    logic [FRAME_BITS-1:0] mask;
    aw   = wide ? wide_aw : narrow_aw;
    mask = (FRAME_BITS'(1) << aw) - FRAME_BITS'(1);
    f    = FRAME_BITS'(RD_OPCODE) << aw;
    f    = f | (FRAME_BITS'(waddr) & mask);
    return f;
  endfunction
endpackage

// File: rtl/eel_tick_gen.sv
module eel_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R10: the half-period counter never passes the divider value
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(DIV));
endmodule

// File: rtl/eel_word_reader.sv
module eel_word_reader
  import eel_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       wide,
  input  logic [7:0] waddr,
  input  logic       so,
  output logic       cs,
  output logic       sck,
  output logic       si,
  output logic       ack,
  output word_t      rdata
);
  localparam int MAXB  = (FRAME_BITS > DATA_BITS) ? FRAME_BITS : DATA_BITS;
  localparam int CNT_W = $clog2(MAXB);

  rd_state_e             st;
  logic                  tick;
  logic                  hcnt;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bcnt;

  eel_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (st != RS_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RS_IDLE;
      cs    <= 1'b0;
      sck   <= 1'b0;
      si    <= 1'b0;
      ack   <= 1'b0;
      rdata <= '0;
      frame <= '0;
      bcnt  <= '0;
      hcnt  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        RS_IDLE: if (req) begin
          frame <= build_frame(waddr, wide, NARROW_AW, WIDE_AW);
          bcnt  <= '0;
          hcnt  <= 1'b0;
          st    <= RS_DESEL;
        end
        RS_DESEL: if (tick) begin
          if (hcnt) begin
            cs    <= 1'b1;
            si    <= frame[FRAME_BITS-1];
            frame <= frame << 1;
            st    <= RS_CMD_LO;
          end else begin
            hcnt <= 1'b1;
          end
        end
        RS_CMD_LO: if (tick) begin
          sck <= 1'b1;
          st  <= RS_CMD_HI;
        end
        RS_CMD_HI: if (tick) begin
          sck <= 1'b0;
          if (bcnt == CNT_W'(FRAME_BITS - 1)) begin
            si   <= 1'b0;
            bcnt <= '0;
            st   <= RS_DAT_LO;
          end else begin
            si    <= frame[FRAME_BITS-1];
            frame <= frame << 1;
            bcnt  <= bcnt + 1'b1;
            st    <= RS_CMD_LO;
          end
        end
        RS_DAT_LO: if (tick) begin
          sck <= 1'b1;
          st  <= RS_DAT_HI;
        end
        RS_DAT_HI: if (tick) begin
          sck   <= 1'b0;
          rdata <= {rdata[DATA_BITS-2:0], so};
          if (bcnt == CNT_W'(DATA_BITS - 1)) begin
            st <= RS_FIN;
          end else begin
            bcnt <= bcnt + 1'b1;
            st   <= RS_DAT_LO;
          end
        end
        RS_FIN: if (tick) begin
          cs  <= 1'b0;
          ack <= 1'b1;
          st  <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  // R2: serial data in holds still while the shift clock is high
  p_di_steady_high_r2: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(si));
  // R3: no clocking while the part is deselected
  p_sck_low_deselected_r3: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !sck);
  // R3: completion is reported only with the part deselected
  p_ack_deselected_r3: assert property (@(posedge clk) disable iff (rst)
    ack |-> !cs);
endmodule

// File: rtl/eel_load_seq.sv
module eel_load_seq
  import eel_pkg::*;
#(
  parameter int          WORD_COUNT = 64,
  parameter logic [15:0] SIGNATURE  = 16'hBABA,
  parameter int          ADDR_WORDS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      ack,
  input  word_t                     rdata,
  output logic                      req,
  output logic                      wide,
  output logic [7:0]                waddr,
  output logic [ADDR_WORDS*16-1:0]  station,
  output logic                      valid,
  output logic                      done
);
  localparam int IW = $clog2(WORD_COUNT);

  sq_state_e               st;
  logic [IW-1:0]           idx;
  word_t                   sum;
  logic                    wide_r;
  logic [ADDR_WORDS*16-1:0] acc;

  assign req   = (st == SQ_KICK) || (st == SQ_REQ);
  assign wide  = (st == SQ_KICK) ? 1'b0 : wide_r;
  assign waddr = 8'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_KICK;
      idx     <= '0;
      sum     <= '0;
      wide_r  <= 1'b0;
      acc     <= '0;
      station <= '0;
      valid   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_KICK: begin
          sum     <= '0;
          idx     <= '0;
          valid   <= 1'b0;
          station <= '0;
          st      <= SQ_PROBE;
        end
        SQ_PROBE: if (ack) begin
          wide_r <= &rdata;
          st     <= SQ_REQ;
        end
        SQ_REQ: st <= SQ_WAIT;
        SQ_WAIT: if (ack) begin
          sum <= sum + rdata;
          for (int k = 0; k < ADDR_WORDS; k++)
            if (idx == IW'(k)) acc[k*16 +: 16] <= rdata;
          if (idx == IW'(WORD_COUNT - 1)) begin
            idx <= '0;
            st  <= SQ_CHECK;
          end else begin
            idx <= idx + 1'b1;
            st  <= SQ_REQ;
          end
        end
        SQ_CHECK: begin
          done <= 1'b1;
          if (sum == SIGNATURE) begin
            valid   <= 1'b1;
            station <= acc;
          end
          st <= SQ_IDLE;
        end
        SQ_IDLE: if (start) st <= SQ_KICK;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: without a valid image the address output is zero
  p_invalid_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (station == '0));
  // R7: the address only moves at load start or at the sum check
  p_station_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (st != SQ_CHECK && st != SQ_KICK) |=> $stable(station));
  // R4: the probe access always uses the narrow address width
  p_probe_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    (req && st == SQ_KICK) |-> !wide);
endmodule

// File: rtl/eeprom_addr_loader.sv
module eeprom_addr_loader
  import eel_pkg::*;
#(
  parameter int          CLK_DIV    = 4,
  parameter int          WORD_COUNT = 64,
  parameter logic [15:0] SIGNATURE  = 16'hBABA,
  parameter int          NARROW_AW  = 6,
  parameter int          WIDE_AW    = 8,
  parameter int          ADDR_WORDS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     ee_cs,
  output logic                     ee_sck,
  output logic                     ee_di,
  input  logic                     ee_do,
  output logic [ADDR_WORDS*16-1:0] station_addr,
  output logic                     addr_valid,
  output logic                     load_done
);
  logic       rd_req;
  logic       rd_wide;
  logic [7:0] rd_addr;
  logic       rd_ack;
  word_t      rd_data;

  eel_word_reader #(
    .DIV       (CLK_DIV),
    .NARROW_AW (NARROW_AW),
    .WIDE_AW   (WIDE_AW)
  ) u_reader (
    .clk   (clk),
    .rst   (rst),
    .req   (rd_req),
    .wide  (rd_wide),
    .waddr (rd_addr),
    .so    (ee_do),
    .cs    (ee_cs),
    .sck   (ee_sck),
    .si    (ee_di),
    .ack   (rd_ack),
    .rdata (rd_data)
  );

  eel_load_seq #(
    .WORD_COUNT (WORD_COUNT),
    .SIGNATURE  (SIGNATURE),
    .ADDR_WORDS (ADDR_WORDS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ack     (rd_ack),
    .rdata   (rd_data),
    .req     (rd_req),
    .wide    (rd_wide),
    .waddr   (rd_addr),
    .station (station_addr),
    .valid   (addr_valid),
    .done    (load_done)
  );
endmodule

// File: tb/eeprom_addr_loader_test.sv
module eeprom_addr_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ee_cs, ee_sck, ee_di;
  logic        ee_do;
  logic [47:0] station_addr;
  logic        addr_valid, load_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_addr_loader #(.CLK_DIV(DIV)) uut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .ee_cs        (ee_cs),
    .ee_sck       (ee_sck),
    .ee_di        (ee_di),
    .ee_do        (ee_do),
    .station_addr (station_addr),
    .addr_valid   (addr_valid),
    .load_done    (load_done)
  );

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [256];
  int          mw = 6;
  int          reads = 0;
  int          op_err = 0;
  int          order_err = 0;
  int          prev_addr = 0;
  bit          m_started = 0, m_sending = 0;
  int          m_cnt = 0;
  logic [15:0] m_sh = '0, m_out = '0;

  initial ee_do = 1'b1;

  always @(posedge ee_sck or negedge ee_cs) begin
    if (!ee_cs) begin
      m_started = 0;
      m_sending = 0;
      ee_do     = 1'b1;
    end else if (m_sending) begin
      ee_do = m_out[15];
      m_out = {m_out[14:0], 1'b1};
    end else if (!m_started) begin
      if (ee_di) begin
        m_started = 1;
        m_cnt     = 0;
        m_sh      = '0;
      end
    end else begin
      m_sh = {m_sh[14:0], ee_di};
      m_cnt++;
      if (m_cnt == 2 + mw) begin
        int a;
        a = int'(m_sh) & ((1 << mw) - 1);
        if (((int'(m_sh) >> mw) & 3) != 2) op_err++;
        if (a != 0 && a != prev_addr + 1) order_err++;
        prev_addr = a;
        m_out     = mem[a];
        m_sending = 1;
        reads++;
      end
    end
  end

  // ---------------- wire monitors ----------------
  int   lo_run = 0, hi_run = 0, done_pulses = 0;
  int   cs_err = 0, sck_err = 0, di_err = 0;
  logic pcs = 1'b0, psck = 1'b0, pdi = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (load_done) done_pulses++;
      if (!ee_cs) begin
        lo_run++;
        if (ee_sck) cs_err++;
      end else begin
        if (!pcs && lo_run < 2*DIV) cs_err++;
        lo_run = 0;
      end
      if (ee_sck) begin
        hi_run++;
        if (psck && ee_di != pdi) di_err++;
      end else begin
        if (psck && hi_run != DIV) sck_err++;
        hi_run = 0;
      end
    end
    pcs  = ee_cs;
    psck = ee_sck;
    pdi  = ee_di;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic build_image(input logic [15:0] w0, input bit corrupt);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 311) ^ 16'h5A0F;
    mem[0] = w0;
    mem[1] = 16'h4433;
    mem[2] = 16'h6655;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'hBABA - s;
    if (corrupt) mem[40] = mem[40] ^ 16'h0100;
  endtask

  task automatic wait_done(input int base);
    while (done_pulses <= base) @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(ee_cs == 0 && ee_sck == 0 && ee_di == 0, "R1", "serial pins in reset",
        {ee_cs, ee_sck, ee_di}, 0);
    chk(addr_valid == 0 && load_done == 0 && station_addr == 0, "R1", "outputs in reset",
        {addr_valid, load_done, station_addr}, 0);
  endtask

  task automatic t_narrow_good;
    int base_r;
    base_r = reads;
    rst = 1'b0;
    wait_done(0);
    chk(done_pulses == 1, "R1", "auto load after reset release", done_pulses, 1);
    chk(reads - base_r == 65, "R6", "narrow access count", reads - base_r, 65);
    chk(addr_valid == 1, "R6", "valid on matching sum", addr_valid, 1);
    chk(station_addr == {mem[2], mem[1], mem[0]}, "R7", "narrow address packing",
        station_addr, {mem[2], mem[1], mem[0]});
    chk(station_addr[7:0] == 8'h11, "R5", "first byte from word0 low", station_addr[7:0], 8'h11);
    @(negedge clk);
    chk(load_done == 0, "R9", "done lasts one cycle", load_done, 0);
    repeat (50) @(negedge clk);
    chk(done_pulses == 1 && addr_valid == 1, "R9", "result held while idle",
        {done_pulses, addr_valid}, {32'd1, 1'b1});
  endtask

  task automatic t_narrow_bad;
    int base_d, base_r;
    build_image(16'h2211, 1'b1);
    base_d = done_pulses;
    base_r = reads;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(addr_valid == 0 && station_addr == 0, "R9", "start clears result",
        {addr_valid, station_addr}, 0);
    wait_done(base_d);
    chk(reads - base_r == 65, "R6", "access count on bad image", reads - base_r, 65);
    chk(addr_valid == 0, "R8", "valid low on sum mismatch", addr_valid, 0);
    chk(station_addr == 0, "R8", "address zero on sum mismatch", station_addr, 0);
  endtask

  task automatic t_wide_good;
    int base_d, base_r;
    mw = 8;
    build_image(16'hFFFE, 1'b0);
    base_d = done_pulses;
    base_r = reads;
    pulse_start();
    wait_done(base_d);
    chk(reads - base_r == 65, "R4", "wide access count", reads - base_r, 65);
    chk(addr_valid == 1, "R4", "wide part loads valid image", addr_valid, 1);
    chk(station_addr == {mem[2], mem[1], mem[0]}, "R7", "wide address packing",
        station_addr, {mem[2], mem[1], mem[0]});
    mw = 6;
  endtask

  task automatic t_start_busy;
    int base_d, base_r;
    build_image(16'h2211, 1'b0);
    base_d = done_pulses;
    base_r = reads;
    pulse_start();
    repeat (2000) @(negedge clk);
    pulse_start();
    wait_done(base_d);
    repeat (600) @(negedge clk);
    chk(done_pulses - base_d == 1, "R9", "start during load ignored",
        done_pulses - base_d, 1);
    chk(reads - base_r == 65 && ee_cs == 0, "R9", "no second load after busy start",
        reads - base_r, 65);
    chk(addr_valid == 1, "R6", "valid after busy start run", addr_valid, 1);
  endtask

  task automatic t_wire_rules;
    chk(op_err == 0, "R2", "opcode field in every frame", op_err, 0);
    chk(order_err == 0, "R6", "ascending word order", order_err, 0);
    chk(di_err == 0, "R2", "di steady while sck high", di_err, 0);
    chk(cs_err == 0, "R3", "deselect time and no clock while deselected", cs_err, 0);
    chk(sck_err == 0, "R10", "sck high level length", sck_err, 0);
  endtask

  bit finished = 0;

  initial begin
    build_image(16'h2211, 1'b0);
    t_reset();
    t_narrow_good();
    t_narrow_bad();
    t_wide_good();
    t_start_busy();
    t_wire_rules();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule